// File: doc/BRIEF.md
# SDRAM Bank Region Decoder

This block decides which of four memory banks owns an incoming 34-bit physical address, and where inside that bank the address falls. Each bank is described by one 32-bit configuration word that carries an enable bit, a base field and a size field. The words are written by software, either straight through a per-bank register or indirectly through an index register and a data window. For every address the block drives a one-hot bank hit, the offset from the hit bank's base, and a miss flag when no enabled bank covers the address.

The 32-bit word reaches a 34-bit space because the base is kept shifted right by two: bits 31:21 of the word become physical address bits 33:23, so every base sits on an 8 MiB boundary. The size is a count of 8 MiB units taken as 1024 minus the 10-bit field in bits 15:6. Only power-of-two counts are legal. Stores pass through a fixed keep-mask. A bank that has no memory fitted, as set by a parameter, ignores stores and always reads zero.

Decode is combinational from the stored words. A register write changes the decode from the clock edge that takes the write.

Top module: `bank_region_decoder`

## Requirements
- R1: After reset every configuration word and the index register read zero. No bank hits, `decodeMiss` is 1 for any address, and `sizeErr` is 0.
- R2: A write stores the data ANDed with 0xFFE0FFC1. Reading the bank back through its direct register (`cfgAddr` 4+b) returns the masked value.
- R3: `cfgAddr` 0 is the index register. Its low 8 bits are stored and read back zero-extended. `cfgAddr` 1 reads or writes bank[index] when index < 4. For any larger index the window reads zero and writes change no bank.
- R4: Bit 0 of a word is the enable. A bank with bit 0 clear never hits.
- R5: The bank base is the word's bits 31:21 placed at physical bits 33:23, with zeros below. Encoding a base therefore takes (base >> 2) & 0xFFE00000.
- R6: Let u = 1024 − word[15:6], where a field of 0 gives 1024. An enabled bank with power-of-two u covers [base, base + u·8 MiB). On a hit, `bankOffset` = address − base. The address equal to the end is not covered.
- R7: An enabled bank whose u is not a power of two raises its bit of `sizeErr` and never hits.
- R8: When enabled banks overlap, only the lowest-numbered covering bank is flagged in `bankHit`, and `bankOffset` is measured from that bank's base. `bankHit` is never more than one-hot.
- R9: When no bank covers the address, `decodeMiss` is 1, `bankHit` is 0 and `bankOffset` is 0. Otherwise `decodeMiss` is 0.
- R10: A bank whose bit in parameter POPULATED is 0 ignores writes on both paths. It reads zero on both paths and never hits. The default POPULATED is 4'b0111, so bank 3 has no memory.
- R11: `cfgAddr` 2 and 3 read zero, and writes to them change no bank or index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select: 0 index, 1 data window, 4..7 direct bank 0..3 |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data (combinational on cfgAddr) |
| reqAddr | input | 34 | Physical address to decode |
| bankHit | output | 4 | One-hot bank hit |
| bankOffset | output | 34 | Offset of reqAddr within the hit bank |
| decodeMiss | output | 1 | No bank covers reqAddr |
| sizeErr | output | 4 | Enabled bank with an illegal size code |

## Verification
The hardest case to reach from the ports is an address that lies exactly on a region edge while two enabled banks overlap. Purely random addresses almost never land there in a 16 GiB space. The stimulus therefore draws addresses relative to a chosen bank's base, spread over twice its span. It also drives directed probes at base−1, base, end−1 and end, with a deliberately overlapping pair of banks, so that priority and the exclusive upper bound are both exercised. Size codes are biased toward powers of two, with some illegal codes mixed in to reach the error path.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int BANK_CNT   = 4;
  localparam int BANK_IDX_W = $clog2(BANK_CNT);
  localparam int WORD_W     = 32;
  localparam int PHYS_W     = 34;
  localparam int UNIT_SHIFT = 23;
  localparam int SIZE_LSB   = 6;
  localparam int SIZE_W     = 10;
  localparam int BASE_LSB   = 21;
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFFE0FFC1;

  typedef struct packed {
    logic                  wrEn;
    logic [BANK_IDX_W-1:0] bank;
    logic [WORD_W-1:0]     data;
  } cfg_strobe_t;
endpackage

// File: rtl/bank_dec_ctrl.sv
module bank_dec_ctrl
  import bank_dec_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cfgWr,
  input  logic [2:0]                       cfgAddr,
  input  logic [WORD_W-1:0]                cfgWrData,
  input  logic [BANK_CNT-1:0][WORD_W-1:0]  bankWords,
  output logic [WORD_W-1:0]                cfgRdData,
  output cfg_strobe_t                      strobe
);
  localparam logic [2:0] SEL_INDEX  = 3'd0;
  localparam logic [2:0] SEL_WINDOW = 3'd1;

  logic [IDX_W-1:0] indexReg;
  logic             idxValid;
  logic             isDirect;

  assign idxValid = (indexReg < IDX_W'(BANK_CNT));
  assign isDirect = cfgAddr[2];

  always_ff @(posedge clk) begin
    if (!rstN) indexReg <= '0;
    else if (cfgWr && cfgAddr == SEL_INDEX) indexReg <= cfgWrData[IDX_W-1:0];
  end

  always_comb begin
    strobe.data = cfgWrData;
    strobe.bank = isDirect ? cfgAddr[BANK_IDX_W-1:0] : indexReg[BANK_IDX_W-1:0];
    strobe.wrEn = cfgWr && (isDirect || (cfgAddr == SEL_WINDOW && idxValid));
  end

  always_comb begin
    cfgRdData = '0;
    if (isDirect) cfgRdData = bankWords[cfgAddr[BANK_IDX_W-1:0]];
    else if (cfgAddr == SEL_INDEX) cfgRdData = WORD_W'(indexReg);
    else if (cfgAddr == SEL_WINDOW && idxValid)
      cfgRdData = bankWords[indexReg[BANK_IDX_W-1:0]];
  end
endmodule

// File: rtl/bank_dec_path.sv
module bank_dec_path
  import bank_dec_pkg::*;
#(
  parameter logic [BANK_CNT-1:0] POPULATED = 4'b0111
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cfg_strobe_t                      strobe,
  input  logic [PHYS_W-1:0]                reqAddr,
  output logic [BANK_CNT-1:0][WORD_W-1:0]  bankWords,
  output logic [BANK_CNT-1:0]              bankHit,
  output logic [PHYS_W-1:0]                bankOffset,
  output logic                             decodeMiss,
  output logic [BANK_CNT-1:0]              sizeErr
);
  localparam int UNITS_W = SIZE_W + 1;
  localparam int BASE_W  = WORD_W - BASE_LSB;

  logic [BANK_CNT-1:0]             hitRaw;
  logic [BANK_CNT-1:0][PHYS_W-1:0] offs;

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [UNITS_W-1:0] units;
    logic               pow2;
    logic [PHYS_W-1:0]  base;
    logic [PHYS_W:0]    endAddr;

    if (POPULATED[b]) begin : g_store
      always_ff @(posedge clk) begin
        if (!rstN) bankWords[b] <= '0;
        else if (strobe.wrEn && strobe.bank == BANK_IDX_W'(b))
          bankWords[b] <= strobe.data & KEEP_MASK;
      end
    end else begin : g_empty
      assign bankWords[b] = '0;
    end

    assign units   = UNITS_W'(1024) - {1'b0, bankWords[b][SIZE_LSB +: SIZE_W]};
    assign pow2    = (units & (units - UNITS_W'(1))) == '0;
    assign base    = {bankWords[b][WORD_W-1 -: BASE_W], {UNIT_SHIFT{1'b0}}};
    assign endAddr = {1'b0, base} + {1'b0, units, {UNIT_SHIFT{1'b0}}};
    assign sizeErr[b] = bankWords[b][0] && !pow2;
    assign hitRaw[b]  = bankWords[b][0] && pow2 && (reqAddr >= base)
                        && ({1'b0, reqAddr} < endAddr);
    assign offs[b]    = reqAddr - base;
  end

  always_comb begin
    bankHit    = '0;
    bankOffset = '0;
    for (int b = BANK_CNT - 1; b >= 0; b--) begin
      if (hitRaw[b]) begin
        bankHit    = '0;
        bankHit[b] = 1'b1;
        bankOffset = offs[b];
      end
    end
  end

  assign decodeMiss = ~|hitRaw;
endmodule

// File: rtl/bank_region_decoder.sv
module bank_region_decoder
  import bank_dec_pkg::*;
#(
  parameter logic [BANK_CNT-1:0] POPULATED = 4'b0111,
  parameter int                  IDX_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [2:0]          cfgAddr,
  input  logic [WORD_W-1:0]   cfgWrData,
  output logic [WORD_W-1:0]   cfgRdData,
  input  logic [PHYS_W-1:0]   reqAddr,
  output logic [BANK_CNT-1:0] bankHit,
  output logic [PHYS_W-1:0]   bankOffset,
  output logic                decodeMiss,
  output logic [BANK_CNT-1:0] sizeErr
);
  cfg_strobe_t                     strobe;
  logic [BANK_CNT-1:0][WORD_W-1:0] bankWords;

  bank_dec_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .bankWords(bankWords),
    .cfgRdData(cfgRdData), .strobe(strobe)
  );

  bank_dec_path #(.POPULATED(POPULATED)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .bankWords(bankWords), .bankHit(bankHit), .bankOffset(bankOffset),
    .decodeMiss(decodeMiss), .sizeErr(sizeErr)
  );
endmodule

// File: rtl/bank_region_decoder_chk.sv
module bank_region_decoder_chk
  import bank_dec_pkg::*;
#(
  parameter logic [BANK_CNT-1:0] POPULATED = 4'b0111,
  parameter int                  IDX_W     = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWr,
  input logic [2:0]          cfgAddr,
  input logic [WORD_W-1:0]   cfgWrData,
  input logic [WORD_W-1:0]   cfgRdData,
  input logic [PHYS_W-1:0]   reqAddr,
  input logic [BANK_CNT-1:0] bankHit,
  input logic [PHYS_W-1:0]   bankOffset,
  input logic                decodeMiss,
  input logic [BANK_CNT-1:0] sizeErr
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (decodeMiss && bankHit == '0 && sizeErr == '0));

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankHit));

  // R9
  miss_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    decodeMiss == (bankHit == '0));

  // R9
  miss_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    decodeMiss |-> bankOffset == '0);

  // R7
  bad_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeErr & bankHit) == '0);

  // R10
  empty_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((bankHit | sizeErr) & ~POPULATED) == '0);
endmodule

bind bank_region_decoder bank_region_decoder_chk #(.POPULATED(POPULATED), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_bank_region_decoder.sv
module test_bank_region_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [2:0]  cfgAddr = 3'd0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [33:0] reqAddr = '0;
  logic [3:0]  bankHit;
  logic [33:0] bankOffset;
  logic        decodeMiss;
  logic [3:0]  sizeErr;

  localparam logic [3:0] POP = 4'b0111;

  int checks = 0;
  int errors = 0;
  logic [31:0] mWord [4];
  logic [7:0]  mIdx;

  bank_region_decoder i_bank_region_decoder (.*);

  always #4 clk = ~clk;

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] mkWord(input logic [33:0] base, input int units, input bit en);
    logic [35:0] b36 = {2'b0, base};
    logic [31:0] sz  = 32'(1024 - units) & 32'h3FF;
    return (32'(b36 >> 2) & 32'hFFE00000) | (sz << 6) | 32'(en);
  endfunction

  function automatic int unitsOf(input logic [31:0] w);
    return 1024 - int'(w[15:6]);
  endfunction

  function automatic bit isPow2(input int u);
    return (u & (u - 1)) == 0;
  endfunction

  function automatic logic [33:0] baseOf(input logic [31:0] w);
    return {w[31:21], 23'b0};
  endfunction

  task automatic expDecode(input logic [33:0] a, output logic [3:0] h,
                           output logic [33:0] off, output logic miss);
    h = '0; off = '0; miss = 1'b1;
    for (int b = 0; b < 4; b++) begin
      longint lo = longint'(baseOf(mWord[b]));
      longint hi = lo + (longint'(unitsOf(mWord[b])) << 23);
      if (miss && mWord[b][0] && isPow2(unitsOf(mWord[b])) &&
          longint'(a) >= lo && longint'(a) < hi) begin
        h[b] = 1'b1; off = 34'(longint'(a) - lo); miss = 1'b0;
      end
    end
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
    if (a == 3'd0) mIdx = d[7:0];
    else if (a == 3'd1) begin
      if (mIdx < 8'd4 && POP[mIdx[1:0]]) mWord[mIdx[1:0]] = d & 32'hFFE0FFC1;
    end else if (a[2] && POP[a[1:0]]) mWord[a[1:0]] = d & 32'hFFE0FFC1;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic probe(input string req, input logic [33:0] a);
    logic [3:0] h; logic [33:0] off; logic miss;
    @(negedge clk);
    reqAddr = a;
    #1;
    expDecode(a, h, off, miss);
    check(req, "bankHit", 64'(bankHit), 64'(h));
    check(req, "bankOffset", 64'(bankOffset), 64'(off));
    check(req, "decodeMiss", 64'(decodeMiss), 64'(miss));
  endtask

  task automatic checkWords(input string req);
    logic [31:0] d;
    for (int b = 0; b < 4; b++) begin
      regRead(3'(4 + b), d);
      check(req, "direct readback", 64'(d), 64'(mWord[b]));
    end
  endtask

  task automatic checkErr(input string req);
    logic [3:0] e;
    for (int b = 0; b < 4; b++) e[b] = mWord[b][0] && !isPow2(unitsOf(mWord[b]));
    @(negedge clk);
    #1 check(req, "sizeErr", 64'(sizeErr), 64'(e));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < 4; b++) mWord[b] = '0;
    mIdx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkWords("R1");
    regRead(3'd0, d); check("R1", "index reset", 64'(d), 64'd0);
    probe("R1", 34'h0);
    probe("R1", 34'h2_0000_0000 - 34'h1);
    checkErr("R1");

    // R2 keep-mask
    regWrite(3'd4, 32'hFFFF_FFFF);
    checkWords("R2");

    // R5 R6 R4 edges: bank0 at 0x1_0000_0000 with 4 units (32 MiB)
    regWrite(3'd4, mkWord(34'h1_0000_0000, 4, 1'b1));
    regRead(3'd4, d); check("R5", "encoded base", 64'(d[31:21]), 64'h200);
    probe("R6", 34'h1_0000_0000);
    probe("R6", 34'h1_0000_0000 - 1);
    probe("R6", 34'h1_0200_0000 - 1);
    probe("R6", 34'h1_0200_0000);
    regWrite(3'd4, mkWord(34'h1_0000_0000, 4, 1'b0));
    probe("R4", 34'h1_0000_0010);

    // R3 indirect window
    regWrite(3'd0, 32'h0000_0102);
    regRead(3'd0, d); check("R3", "index readback", 64'(d), 64'h02);
    regWrite(3'd1, mkWord(34'h0_8000_0000, 8, 1'b1) | 32'h001F_003E);
    regRead(3'd1, d); check("R3", "window read", 64'(d), 64'(mWord[2]));
    checkWords("R3");
    regWrite(3'd0, 32'h7);
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, d); check("R3", "out-of-range window", 64'(d), 64'd0);
    checkWords("R3");

    // R11 unmapped selects
    regWrite(3'd2, 32'hFFFF_FFFF);
    regWrite(3'd3, 32'hFFFF_FFFF);
    regRead(3'd2, d); check("R11", "sel2 read", 64'(d), 64'd0);
    regRead(3'd3, d); check("R11", "sel3 read", 64'(d), 64'd0);
    regRead(3'd0, d); check("R11", "index kept", 64'(d), 64'h7);
    checkWords("R11");

    // R10 unpopulated bank 3
    regWrite(3'd7, mkWord(34'h0, 1024, 1'b1));
    regWrite(3'd0, 32'h3);
    regWrite(3'd1, mkWord(34'h0, 1024, 1'b1));
    regRead(3'd1, d); check("R10", "window bank3", 64'(d), 64'd0);
    checkWords("R10");
    probe("R10", 34'h0_0000_1000);

    // R8 overlap: bank1 covers bank2's region
    regWrite(3'd5, mkWord(34'h0_8000_0000, 16, 1'b1));
    probe("R8", 34'h0_8000_0004);
    probe("R8", 34'h0_8800_0000);
    regWrite(3'd5, mkWord(34'h0_8200_0000, 2, 1'b1));
    probe("R8", 34'h0_8200_0000);
    probe("R8", 34'h0_8100_0000);

    // R7 non-power-of-two
    regWrite(3'd6, mkWord(34'h0_8000_0000, 3, 1'b1));
    checkErr("R7");
    probe("R7", 34'h0_8000_0000);

    // R9 miss
    probe("R9", 34'h3_FFFF_FFFF);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int k = $urandom % 4;
      int u = ($urandom % 5 == 0) ? 1 + ($urandom % 1024) : (1 << ($urandom % 11));
      logic [33:0] bs = {11'($urandom), 23'b0};
      logic [31:0] w = mkWord(bs, u, ($urandom % 4) != 0) | ($urandom & 32'h001F_003E);
      if ($urandom % 2) regWrite(3'(4 + k), w);
      else begin regWrite(3'd0, 32'(k)); regWrite(3'd1, w); end
      if (it % 25 == 0) begin checkWords("R2"); checkErr("R7"); end
      for (int j = 0; j < 4; j++) begin
        int t = $urandom % 4;
        longint span = longint'(unitsOf(mWord[t])) << 23;
        longint a = longint'(baseOf(mWord[t])) - (span / 2) +
                    longint'({$urandom, $urandom} % longint'(2 * span));
        probe("R6", 34'(a));
      end
      probe("R9", 34'({$urandom, $urandom}));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule